// File: doc/BRIEF.md
# Addressed Serial DAC Register Front End

This block is the digital input stage of a 12-bit converter that shares one serial bus with up to seven others. A host shifts 16-bit words in over three wires: serial data, serial clock and an active-low select. Each word carries a 3-bit device address and a 12-bit conversion code. Each device compares the address with its own three strap inputs. A device whose straps match copies the code into its output latch at the moment the select line is released. Every other device keeps the value it already holds.

The serial inputs are asynchronous to the block. They are brought into a faster system clock domain through two-stage synchronizers. Edges of the serial clock and the select line are then found by comparing each synchronized signal with its value one cycle earlier. The block also has an asynchronous active-low reset and a standby request. The standby request is registered and passed on to the analog section.

Top module: `spi_dac_front`

## Requirements
- R1: Serial data is captured on each rising edge of `sclk` while `cs_n` is low, most significant bit first.
- R2: Word layout: bit 15 is ignored, bits 14:12 are the target address and bits 11:0 are the code placed on `code_o`.
- R3: `code_o` changes only on a rising edge of `cs_n`. While `cs_n` stays low it holds its value, even after 16 or more bits have arrived.
- R4: The latch is written only when bits 14:12 equal `addr_strap`. When they differ, `code_o` keeps its previous value.
- R5: When more than 16 bits are clocked in during one select period, the last 16 bits received form the word.
- R6: When `cs_n` rises after fewer than 16 serial clock edges, the frame is dropped and `code_o` is unchanged.
- R7: While `rst_n` is low, `code_o` reads 0. After reset is released, a partial frame that was in progress is not carried over into the next frame.
- R8: `standby_o` equals the `stby` input as sampled on the previous `clk` edge.
- R9: A committed code appears on `code_o` no later than the third `clk` rising edge after `cs_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock (asynchronous) |
| sdi | input | 1 | Serial data (asynchronous) |
| cs_n | input | 1 | Frame select, active low (asynchronous) |
| addr_strap | input | 3 | Device address set by straps |
| stby | input | 1 | Standby request |
| code_o | output | 12 | Latched conversion code |
| standby_o | output | 1 | Registered standby indication |

## Verification
The hardest case to reach is a frame longer than 16 bits whose oldest bits would have selected a different device, or would have carried a different code, than its newest 16 bits. The bench sends frames of random length between 12 and 24 bits, filled with random data. It changes the straps now and then, so that address matches and mismatches both occur often. It also directs frames with leading junk that differs from the final word, and resets the block in the middle of a frame. Before each select release it checks that `code_o` has not moved yet.

// File: rtl/spi_dac_front.sv
module spi_dac_front #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 12,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr_strap,
  input  logic              stby,
  output logic [CODE_W-1:0] code_o,
  output logic              standby_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [1:0] sclk_sy, sdi_sy, cs_sy;
  logic       sclk_d, cs_d;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  wire sclk_rise = sclk_sy[1] & ~sclk_d;
  wire cs_rise   = cs_sy[1] & ~cs_d;
  wire full      = (cnt == CNT_W'(WORD_W));
  wire hit       = (shreg[CODE_W +: ADDR_W] == addr_strap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      sdi_sy  <= '0;
      cs_sy   <= '1;
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[0], sclk};
      sdi_sy  <= {sdi_sy[0], sdi};
      cs_sy   <= {cs_sy[0], cs_n};
      sclk_d  <= sclk_sy[1];
      cs_d    <= cs_sy[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (cs_sy[1]) begin
      cnt <= '0;
    end else if (sclk_rise) begin
      shreg <= {shreg[WORD_W-2:0], sdi_sy[1]};
      if (!full) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o    <= '0;
      standby_o <= 1'b0;
    end else begin
      standby_o <= stby;
      if (cs_rise && full && hit) code_o <= shreg[CODE_W-1:0];
    end
  end

  a_r3_only_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(code_o));
  a_r4_mismatch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !hit) |=> $stable(code_o));
  a_r6_short_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !full) |=> $stable(code_o));
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_W));
  a_r7_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> code_o == '0);
  a_r8_standby_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stby) |=> standby_o);
endmodule

// File: tb/spi_dac_front_test.sv
module spi_dac_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, stby = 1'b0;
  logic [2:0]  addr_strap = 3'd5;
  logic [11:0] code_o;
  logic        standby_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [11:0] exp_code = '0;

  spi_dac_front uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
    .addr_strap(addr_strap), .stby(stby), .code_o(code_o), .standby_o(standby_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] model(input logic [11:0] cur, input logic [31:0] v,
                                        input int n, input logic [2:0] a);
    if (n < 16) return cur;
    if (v[14:12] != a) return cur;
    return v[11:0];
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] v, input int n, input string req);
    cs_n = 1'b0;
    wait_clk(HALF);
    shift_bits(v, n);
    wait_clk(HALF + 3);
    check({req, "/R3 before release"}, code_o, exp_code);
    cs_n = 1'b1;
    exp_code = model(exp_code, v, n, addr_strap);
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    check({req, "/R9"}, code_o, exp_code);
    wait_clk(2);
  endtask

  initial begin
    void'($urandom(32'd4242));
    wait_clk(4);
    check("R7 reset state", code_o, 12'h000);
    checks++; if (standby_o !== 1'b0) begin errors++; $display("FAIL R8: actual=%b expected=0", standby_o); end
    rst_n = 1'b1;
    wait_clk(3);
    frame(32'h0000_5ABC, 16, "R1 R2");
    frame(32'h0000_D123, 16, "R2 bit15 ignored");
    frame(32'h0000_3777, 16, "R4 mismatch");
    frame(32'h0000_5FFF, 12, "R6 short");
    frame(32'h0000_5000, 15, "R6 fifteen");
    frame(32'h0FFF_5321, 28, "R5 long");
    frame(32'h0000_A5E4, 24, "R5 stale address");
    frame(32'h0000_0000, 0, "R6 empty");
    frame(32'h0000_5000, 16, "R1 zero code");
    frame(32'h0000_5FFF, 16, "R1 full code");
    cs_n = 1'b0; wait_clk(HALF);
    shift_bits(32'h0000_0055, 8);
    rst_n = 1'b0; wait_clk(2);
    exp_code = '0;
    check("R7 reset mid-frame", code_o, 12'h000);
    cs_n = 1'b1; rst_n = 1'b1; wait_clk(3);
    frame(32'h0000_5AAA, 8, "R7 no carryover");
    for (int k = 0; k < 70; k++) begin
      logic [31:0] v;
      int n;
      v = $urandom;
      n = 12 + ($urandom % 13);
      if ($urandom % 8 == 0) addr_strap = 3'($urandom);
      if ($urandom % 2 == 0) v[14:12] = addr_strap;
      frame(v, n, "random R4 R5 R6");
      stby = 1'($urandom);
      wait_clk(2);
      checks++;
      if (standby_o !== stby) begin
        errors++;
        $display("FAIL R8: actual=%b expected=%b", standby_o, stby);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule